// File: doc/BRIEF.md
# Three-Bus Instruction Fetch Datapath

This block is the instruction-fetch slice of a processor datapath. It has three internal buses. Two source buses feed the inputs of a two-input ALU, and one result bus carries the ALU output back to the registers. No register is ever wired to another register: every transfer leaves a register on a source bus, passes through the ALU (which adds or passes one operand) and lands on the result bus. The slice holds the program counter, the memory address register, the memory data register and the instruction register. A three-slot sequencer drives the bus enables, the ALU function and the register loads.

A fetch takes three clocks. The first slot copies the program counter to the address register and raises a read request. Memory is busy in the second slot, so that slot is used to add one to the program counter in a single pass through the ALU. The third slot moves the fetched word from the data register into the instruction register. Memory answers through a data/valid pair that loads the data register directly. A start input gates each new fetch, and a one-cycle done pulse marks each completed fetch.

Top module: `fetch_datapath`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the program counter, address, data and instruction registers to zero. It puts the sequencer in slot T0 (state code 0) with fetch_done low.
- R2: In slot T0 with start low, the sequencer stays in T0. mem_read is low, all three buses read zero, and no register changes.
- R3: In slot T0 with start high, bus1 carries the program counter, the ALU passes bus1 to bus3, and mem_read is high. At the next edge the address register (mem_addr) takes that program counter value.
- R4: In slot T1 (state code 1), bus1 carries the program counter, bus2 carries the constant 1, and bus3 carries their sum. mem_read is low. The program counter takes that sum at the next edge, so the increment costs exactly one cycle.
- R5: In slot T2 (state code 2), bus2 carries the data register, bus1 reads zero, and bus3 equals bus2. The instruction register takes that value at the next edge.
- R6: Once started, the sequencer moves T0 to T1 to T2 on successive clocks. After T2 it returns to T0.
- R7: fetch_done is high for exactly the one cycle that follows a T2 slot, and low otherwise.
- R8: The data register loads mem_rdata at every edge where mem_valid is high, and holds otherwise. A fetch with no valid response places the previous data register value in the instruction register.
- R9: A bus with no source enabled reads zero: bus2 in slot T0, and bus1 in slot T2.
- R10: With start held high, fetches run back to back with no idle cycle. Each fetch raises the program counter by one and fetches from the previous program counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Permits a new fetch to begin in slot T0 |
| mem_rdata | input | 32 | Word returned by memory |
| mem_valid | input | 1 | mem_rdata is valid; loads the data register |
| mem_read | output | 1 | Read request, high in an active T0 slot |
| mem_addr | output | 32 | Address register contents |
| fetch_done | output | 1 | One-cycle pulse after each completed fetch |
| state | output | 2 | Sequencer slot: 0 = T0, 1 = T1, 2 = T2 |
| pc | output | 32 | Program counter |
| ir | output | 32 | Instruction register |
| mbr | output | 32 | Memory data register |
| bus1 | output | 32 | ALU source bus 1 |
| bus2 | output | 32 | ALU source bus 2 |
| bus3 | output | 32 | ALU result bus |

## Verification
Suppose the sequencer enters the wrong slot. The bus pattern in that same cycle shows it: bus2 carries the constant 1 only in T1, and it carries the data register only in T2. The state output and fetch_done show the error by the next cycle. A wrong program counter shows on bus1 during the next active T0, and on mem_addr one edge later. A wrong data register load shows on bus2 in T2, and in the instruction register one edge after that. No fault can therefore stay hidden for longer than one fetch.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    typedef enum logic [1:0] {
        ST_T0 = 2'd0,
        ST_T1 = 2'd1,
        ST_T2 = 2'd2
    } slot_e;

    typedef enum logic [1:0] {
        ALU_NOP  = 2'd0,
        ALU_ADD  = 2'd1,
        ALU_PASS1 = 2'd2,
        ALU_PASS2 = 2'd3
    } alu_op_e;

    // Source counts on each ALU input bus and their positions
    localparam int unsigned SRC1_N   = 1;
    localparam int unsigned SRC1_PC  = 0;
    localparam int unsigned SRC2_N   = 2;
    localparam int unsigned SRC2_ONE = 0;
    localparam int unsigned SRC2_MBR = 1;

    typedef struct packed {
        logic [SRC1_N-1:0] src1_en;
        logic [SRC2_N-1:0] src2_en;
        alu_op_e           op;
        logic              ld_mar;
        logic              ld_pc;
        logic              ld_ir;
        logic              rd_req;
        logic              done_set;
    } ctrl_t;

endpackage

// File: rtl/fetch_bus_mux.sv
module fetch_bus_mux #(
    parameter int unsigned W = 32,
    parameter int unsigned N = 2
) (
    input  logic [N-1:0]        en,
    input  logic [N-1:0][W-1:0] src,
    output logic [W-1:0]        bus
);

    logic [N-1:0][W-1:0] masked;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_drv
            assign masked[gi] = en[gi] ? src[gi] : '0;
        end
    endgenerate

    always_comb begin
        bus = '0;
        for (int i = 0; i < N; i++) begin
            bus = bus | masked[i];
        end
    end

endmodule

// File: rtl/fetch_alu.sv
module fetch_alu
    import fetch_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    always_comb begin
        case (op)
            ALU_ADD:   y = a + b;
            ALU_PASS1: y = a;
            ALU_PASS2: y = b;
            default:   y = '0;
        endcase
    end

endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer
    import fetch_pkg::*;
(
    input  slot_e slot_q,
    input  logic  start,
    output slot_e slot_d,
    output ctrl_t ctrl
);

    always_comb begin
        ctrl   = '0;
        ctrl.op = ALU_NOP;
        slot_d = slot_q;
        case (slot_q)
            ST_T0: begin
                if (start) begin
                    ctrl.src1_en[SRC1_PC] = 1'b1;
                    ctrl.op               = ALU_PASS1;
                    ctrl.ld_mar           = 1'b1;
                    ctrl.rd_req           = 1'b1;
                    slot_d                = ST_T1;
                end
            end
            ST_T1: begin
                ctrl.src1_en[SRC1_PC]  = 1'b1;
                ctrl.src2_en[SRC2_ONE] = 1'b1;
                ctrl.op                = ALU_ADD;
                ctrl.ld_pc             = 1'b1;
                slot_d                 = ST_T2;
            end
            ST_T2: begin
                ctrl.src2_en[SRC2_MBR] = 1'b1;
                ctrl.op                = ALU_PASS2;
                ctrl.ld_ir             = 1'b1;
                ctrl.done_set          = 1'b1;
                slot_d                 = ST_T0;
            end
            default: begin
                slot_d = ST_T0;
            end
        endcase
    end

endmodule

// File: rtl/fetch_datapath.sv
module fetch_datapath
    import fetch_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] mem_rdata,
    input  logic         mem_valid,
    output logic         mem_read,
    output logic [W-1:0] mem_addr,
    output logic         fetch_done,
    output logic [1:0]   state,
    output logic [W-1:0] pc,
    output logic [W-1:0] ir,
    output logic [W-1:0] mbr,
    output logic [W-1:0] bus1,
    output logic [W-1:0] bus2,
    output logic [W-1:0] bus3
);

    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        slot_e        slot;
        logic [W-1:0] pc;
        logic [W-1:0] mar;
        logic [W-1:0] mbr;
        logic [W-1:0] ir;
        logic         done;
    } regs_t;

    localparam regs_t REGS_RST = '{slot: ST_T0, pc: '0, mar: '0, mbr: '0, ir: '0, done: 1'b0};

    regs_t r_q, r_d;
    slot_e slot_d;
    ctrl_t ctrl;

    logic [SRC1_N-1:0][W-1:0] src1;
    logic [SRC2_N-1:0][W-1:0] src2;
    logic [W-1:0]             b1, b2, b3;

    fetch_sequencer u_seq (
        .slot_q (r_q.slot),
        .start  (start),
        .slot_d (slot_d),
        .ctrl   (ctrl)
    );

    always_comb begin
        src1[SRC1_PC]  = r_q.pc;
        src2[SRC2_ONE] = ONE;
        src2[SRC2_MBR] = r_q.mbr;
    end

    fetch_bus_mux #(.W(W), .N(SRC1_N)) u_mux1 (
        .en  (ctrl.src1_en),
        .src (src1),
        .bus (b1)
    );

    fetch_bus_mux #(.W(W), .N(SRC2_N)) u_mux2 (
        .en  (ctrl.src2_en),
        .src (src2),
        .bus (b2)
    );

    fetch_alu #(.W(W)) u_alu (
        .op (ctrl.op),
        .a  (b1),
        .b  (b2),
        .y  (b3)
    );

    always_comb begin
        r_d      = r_q;
        r_d.slot = slot_d;
        r_d.done = ctrl.done_set;
        if (ctrl.ld_mar) r_d.mar = b3;
        if (ctrl.ld_pc)  r_d.pc  = b3;
        if (ctrl.ld_ir)  r_d.ir  = b3;
        if (mem_valid)   r_d.mbr = mem_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= REGS_RST;
        else     r_q <= r_d;
    end

    assign mem_read   = ctrl.rd_req;
    assign mem_addr   = r_q.mar;
    assign fetch_done = r_q.done;
    assign state      = r_q.slot;
    assign pc         = r_q.pc;
    assign ir         = r_q.ir;
    assign mbr        = r_q.mbr;
    assign bus1       = b1;
    assign bus2       = b2;
    assign bus3       = b3;

endmodule

// File: rtl/fetch_datapath_chk.sv
module fetch_datapath_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         mem_read,
    input logic [W-1:0] mem_addr,
    input logic         fetch_done,
    input logic [1:0]   state,
    input logic [W-1:0] pc,
    input logic [W-1:0] ir,
    input logic [W-1:0] mbr,
    input logic [W-1:0] bus3
);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd0 && !start) |-> (!mem_read && bus3 == '0));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd0 && !start) |=> (state == 2'd0 && pc == $past(pc)));

    assert_mar_load_R3: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd0 && start) |=> (mem_addr == $past(pc)));

    assert_pc_step_R4: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd1) |=> (pc == $past(pc) + W'(1)));

    assert_ir_load_R5: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd2) |=> (ir == $past(mbr)));

    assert_t1_to_t2_R6: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd1) |=> (state == 2'd2));

    assert_t2_to_t0_R6: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd2) |=> (state == 2'd0));

    assert_done_after_t2_R7: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd2) |=> fetch_done);

    assert_done_only_t0_R7: assert property (@(posedge clk) disable iff (rst)
        fetch_done |-> (state == 2'd0));

endmodule

bind fetch_datapath fetch_datapath_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .mem_read   (mem_read),
    .mem_addr   (mem_addr),
    .fetch_done (fetch_done),
    .state      (state),
    .pc         (pc),
    .ir         (ir),
    .mbr        (mbr),
    .bus3       (bus3)
);

// File: tb/fetch_datapath_tb.sv
module fetch_datapath_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [W-1:0] mem_rdata;
    logic         mem_valid;
    logic         mem_read;
    logic [W-1:0] mem_addr;
    logic         fetch_done;
    logic [1:0]   state;
    logic [W-1:0] pc, ir, mbr, bus1, bus2, bus3;

    int n_checks = 0;
    int n_fail   = 0;
    logic [W-1:0] exp_pc = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_datapath #(.W(W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .mem_rdata  (mem_rdata),
        .mem_valid  (mem_valid),
        .mem_read   (mem_read),
        .mem_addr   (mem_addr),
        .fetch_done (fetch_done),
        .state      (state),
        .pc         (pc),
        .ir         (ir),
        .mbr        (mbr),
        .bus1       (bus1),
        .bus2       (bus2),
        .bus3       (bus3)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // advance one cycle; return at the falling edge, settled for sampling
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; mem_valid = 1'b0; mem_rdata = '0;
        tick(); tick();
        rst = 1'b0;
        #1;
        chk("R1 pc", pc, '0);
        chk("R1 mar", mem_addr, '0);
        chk("R1 mbr", mbr, '0);
        chk("R1 ir", ir, '0);
        chk("R1 state", W'(state), W'(0));
        chk("R1 done", W'(fetch_done), W'(0));
        exp_pc = '0;
    endtask

    task automatic t_idle();
        logic [W-1:0] ir0, mar0;
        ir0 = ir; mar0 = mem_addr;
        start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R2 state", W'(state), W'(0));
            chk("R2 read", W'(mem_read), W'(0));
            chk("R2 bus1", bus1, '0);
            chk("R2 bus2", bus2, '0);
            chk("R2 bus3", bus3, '0);
            chk("R2 pc", pc, exp_pc);
            chk("R2 ir", ir, ir0);
            chk("R2 mar", mem_addr, mar0);
        end
    endtask

    // one fetch from an idle T0; respond selects whether memory answers
    task automatic t_fetch(input logic respond, input logic [W-1:0] word);
        logic [W-1:0] old_mbr, exp_ir;
        old_mbr = mbr;
        exp_ir  = respond ? word : old_mbr;
        start = 1'b1; #1;
        chk("R3 state", W'(state), W'(0));
        chk("R3 bus1", bus1, exp_pc);
        chk("R3 bus3", bus3, exp_pc);
        chk("R3 read", W'(mem_read), W'(1));
        chk("R9 bus2 idle in T0", bus2, '0);
        tick();
        start = 1'b0;
        chk("R6 T1", W'(state), W'(1));
        chk("R3 mar", mem_addr, exp_pc);
        chk("R4 bus1", bus1, exp_pc);
        chk("R4 bus2", bus2, W'(1));
        chk("R4 bus3", bus3, exp_pc + W'(1));
        chk("R4 read", W'(mem_read), W'(0));
        mem_valid = respond; mem_rdata = word;
        tick();
        mem_valid = 1'b0; mem_rdata = '0;
        exp_pc = exp_pc + W'(1);
        chk("R6 T2", W'(state), W'(2));
        chk("R4 pc", pc, exp_pc);
        chk("R8 mbr", mbr, exp_ir);
        chk("R5 bus2", bus2, exp_ir);
        chk("R5 bus3", bus3, exp_ir);
        chk("R9 bus1 idle in T2", bus1, '0);
        chk("R7 done low in T2", W'(fetch_done), W'(0));
        tick();
        chk("R6 back T0", W'(state), W'(0));
        chk("R5 ir", ir, exp_ir);
        chk("R7 done", W'(fetch_done), W'(1));
        tick();
        chk("R7 done drop", W'(fetch_done), W'(0));
        chk("R2 hold", W'(state), W'(0));
    endtask

    task automatic t_back_to_back();
        logic [W-1:0] pc0;
        pc0 = exp_pc;
        start = 1'b1;
        for (int f = 0; f < 3; f++) begin
            #1;
            chk("R10 T0", W'(state), W'(0));
            chk("R10 bus1", bus1, exp_pc);
            tick();
            chk("R10 T1", W'(state), W'(1));
            chk("R10 mar", mem_addr, exp_pc);
            chk("R7 no done in T1", W'(fetch_done), W'(0));
            mem_valid = 1'b1; mem_rdata = 32'hC0DE_0000 + W'(f);
            tick();
            mem_valid = 1'b0;
            exp_pc = exp_pc + W'(1);
            chk("R10 T2", W'(state), W'(2));
            tick();
            chk("R10 ir", ir, 32'hC0DE_0000 + W'(f));
            chk("R7 done b2b", W'(fetch_done), W'(1));
        end
        start = 1'b0;
        chk("R10 pc", pc, pc0 + W'(3));
        tick();
        chk("R7 done clear", W'(fetch_done), W'(0));
    endtask

    task automatic t_mbr_direct();
        mem_valid = 1'b1; mem_rdata = 32'h5A5A_1234;
        tick();
        mem_valid = 1'b0; mem_rdata = 32'hFFFF_FFFF;
        chk("R8 load idle", mbr, 32'h5A5A_1234);
        tick();
        chk("R8 hold", mbr, 32'h5A5A_1234);
        chk("R2 state", W'(state), W'(0));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_idle();
        t_fetch(1'b1, 32'hDEAD_BEEF);
        t_fetch(1'b1, 32'h0000_0001);
        t_fetch(1'b0, 32'h1111_2222);
        t_mbr_direct();
        t_fetch(1'b0, 32'h0);
        t_back_to_back();
        t_idle();
        t_reset();
        t_fetch(1'b1, 32'h8000_0000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule